// File: doc/BRIEF.md
# Descriptor-Chained Frame DMA Fetcher

This block loads, once per display frame, a four-word descriptor for each of a set of display DMA channels. A pulse on `frame_start` begins a pass. The pass visits the channels in ascending order and skips the disabled ones. For each enabled channel it picks a descriptor address and checks that the whole 16-byte descriptor lies inside one of two permitted address windows. It then reads the four words over a single-word memory read port and stores them into per-channel registers that software can read back. When the pass has visited every channel, `done` pulses for one cycle.

The descriptor address comes from one of two places. A one-shot branch register, when its pending bit is set, redirects the chain for one frame and clears that bit when it is used. Otherwise the address is the channel's stored next-descriptor pointer. The next-descriptor pointer is itself replaced by the first word of every descriptor that is fetched, so the chain advances by itself from frame to frame. A bus-error pulse reports any of three cases: a descriptor address that fails the window check, a source address of zero, or a source address outside the windows.

The memory request side is valid/ready. The fetcher presents one word address and holds the address and `mem_req_valid` unchanged until `mem_req_ready` is seen high at a clock edge. It never has more than one read outstanding. The response side has no back-pressure: the fetcher accepts `mem_rsp_valid` in any cycle. The memory must return exactly one response per accepted request, and it must do so in order and no earlier than the cycle after acceptance.

Top module: `frame_desc_loader`

## Requirements
- R1: After reset every register reads zero, and `busy`, `done`, `mem_req_valid`, `bus_err` and `branch_evt` are low.
- R2: Channel c's branch register sits at byte offset 0x100+4c. A write stores the data ANDed with 0xFFFFFFF3. Bit 0 means a branch is pending, bit 1 asks for a branch event, and bits 31:4 hold the descriptor address.
- R3: Channel c's registers sit at offset 0x200+16c, in this order: next-descriptor pointer (+0), source (+4), frame ID (+8), command (+12). A pointer write stores the data with bits 3:0 forced to zero. The source, ID and command registers ignore writes. Reads of unmapped offsets return zero.
- R4: A `frame_start` that arrives while the block is idle clears every channel's source register and starts a pass. A `frame_start` that arrives while busy is ignored. Each pass ends with exactly one single-cycle `done`, after which `busy` is low.
- R5: A disabled channel causes no memory traffic and no events. Its registers keep their values, except the source register, which the pass start has already cleared.
- R6: If an enabled channel's branch-pending bit is set, its descriptor address is branch bits 31:4 with four zero bits appended. The pending bit is cleared, and `branch_evt[c]` pulses if bit 1 is set.
- R7: Without a pending branch, the descriptor address is the stored next-descriptor pointer.
- R8: If the 16 bytes starting at the descriptor address do not lie entirely inside one window, the fetch is skipped, the channel's registers are left unchanged, and `bus_err[c]` pulses.
- R9: The four words are read at the descriptor address +0, +4, +8 and +12, in that order. They are stored as next pointer (stored unmasked), source, ID and command.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay stable. Only one read is ever outstanding.
- R11: After the four words are loaded, `bus_err[c]` pulses if the source is zero or lies outside both windows.
- R12: Channels are handled strictly in ascending index order, so at most one bit of `bus_err` or `branch_evt` is set in any cycle.
- R13: When a register-port write and an update by the fetcher hit the same register in the same cycle, the written value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begins a descriptor pass when idle |
| ch_enable | input | NUM_CH | Per-channel enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Single-cycle end-of-pass pulse |
| branch_evt | output | NUM_CH | Branch-taken event, one pulse per channel |
| bus_err | output | NUM_CH | Bus-error event, one pulse per channel |

## Verification
Two functions can touch channel 0's branch register in the same cycle. The sequencer consumes a pending branch and clears its bit in the cycle after `frame_start`, and software may write a new branch value in that very cycle. The bench provokes this by driving the register write one cycle after the frame-start pulse, with channel 0 holding a pending branch. It judges the result in two ways. The memory address log must show that the fetch used the old branch address. The branch register must read back the newly written value, with its pending bit still set, so that the next pass follows the new branch.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam logic [11:0] BR_OFF    = 12'h100;
  localparam logic [11:0] CH_OFF    = 12'h200;
  localparam int          CH_STRIDE = 16;
  localparam logic [31:0] BR_MASK   = 32'hFFFF_FFF3;
  localparam int          DESC_WORDS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_WAIT,
    ST_CHECK,
    ST_FIN
  } fdl_state_e;
endpackage

// File: rtl/fdl_win_check.sv
module fdl_win_check #(
  parameter int          SPAN      = 16,
  parameter logic [31:0] W0_BASE   = 32'h1000_0000,
  parameter logic [31:0] W0_SIZE   = 32'h0100_0000,
  parameter logic [31:0] W1_BASE   = 32'h4000_0000,
  parameter logic [31:0] W1_SIZE   = 32'h0001_0000
) (
  input  logic [31:0] addr_i,
  output logic        ok_o
);
  localparam int NWIN = 2;
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [32:0] LO = {1'b0, (w == 0) ? W0_BASE : W1_BASE};
    localparam logic [32:0] HI = LO + {1'b0, (w == 0) ? W0_SIZE : W1_SIZE};
    logic [32:0] a_ext;
    assign a_ext  = {1'b0, addr_i};
    assign hit[w] = (a_ext >= LO) && ((a_ext + 33'(SPAN)) <= HI);
  end

  assign ok_o = |hit;
endmodule

// File: rtl/fdl_chan_regs.sv
module fdl_chan_regs
  import fdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_br_we,
  input  logic        sw_ptr_we,
  input  logic [31:0] sw_wdata,
  input  logic        hw_br_clr,
  input  logic        hw_src_clr,
  input  logic [3:0]  hw_we,
  input  logic [31:0] hw_data,
  output logic [31:0] br_o,
  output logic [31:0] ptr_o,
  output logic [31:0] src_o,
  output logic [31:0] id_o,
  output logic [31:0] cmd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_o  <= '0;
      ptr_o <= '0;
      src_o <= '0;
      id_o  <= '0;
      cmd_o <= '0;
    end else begin
      // register-port writes take precedence over fetcher updates
      if (sw_br_we)       br_o    <= sw_wdata & BR_MASK;
      else if (hw_br_clr) br_o[0] <= 1'b0;

      if (sw_ptr_we)      ptr_o <= {sw_wdata[31:4], 4'h0};
      else if (hw_we[0])  ptr_o <= hw_data;

      if (hw_we[1])        src_o <= hw_data;
      else if (hw_src_clr) src_o <= '0;

      if (hw_we[2]) id_o  <= hw_data;
      if (hw_we[3]) cmd_o <= hw_data;
    end
  end
endmodule

// File: rtl/fdl_seq.sv
module fdl_seq
  import fdl_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH-1:0][31:0] br_i,
  input  logic [NUM_CH-1:0][31:0] ptr_i,
  input  logic [NUM_CH-1:0][31:0] src_i,
  input  logic                    desc_ok_i,
  input  logic                    src_ok_i,
  output logic [31:0]             cand_addr_o,
  output logic [31:0]             chk_src_o,
  output logic [CH_W-1:0]         cur_ch_o,
  output logic                    br_clr_o,
  output logic                    src_clr_o,
  output logic [3:0]              ld_we_o,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [31:0]             mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NUM_CH-1:0]       bus_err_o,
  output logic [NUM_CH-1:0]       branch_evt_o
);
  fdl_state_e      state_q;
  logic [CH_W-1:0] ch_q;
  logic [1:0]      word_q;
  logic [31:0]     base_q;
  logic [31:0]     cur_br;
  logic            last_ch;

  assign cur_br      = br_i[ch_q];
  assign cand_addr_o = cur_br[0] ? (cur_br & 32'hFFFF_FFF0) : ptr_i[ch_q];
  assign chk_src_o   = src_i[ch_q];
  assign cur_ch_o    = ch_q;
  assign last_ch     = (ch_q == CH_W'(NUM_CH - 1));
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = base_q + {28'h0, word_q, 2'b00};

  always_comb begin
    br_clr_o     = 1'b0;
    src_clr_o    = 1'b0;
    ld_we_o      = '0;
    bus_err_o    = '0;
    branch_evt_o = '0;
    case (state_q)
      ST_IDLE: src_clr_o = frame_start_i;
      ST_SCAN: begin
        if (ch_en_i[ch_q]) begin
          br_clr_o = cur_br[0];
          if (cur_br[0] && cur_br[1]) branch_evt_o[ch_q] = 1'b1;
          if (!desc_ok_i) bus_err_o[ch_q] = 1'b1;
        end
      end
      ST_WAIT: if (mem_rsp_valid_i) ld_we_o[word_q] = 1'b1;
      ST_CHECK: begin
        if (!src_ok_i || (chk_src_o == 32'h0)) bus_err_o[ch_q] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      word_q  <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (frame_start_i) begin
            ch_q    <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (ch_en_i[ch_q] && desc_ok_i) begin
            base_q  <= cand_addr_o;
            word_q  <= '0;
            state_q <= ST_REQ;
          end else if (last_ch) begin
            state_q <= ST_FIN;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (word_q == 2'(DESC_WORDS - 1)) begin
              state_q <= ST_CHECK;
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        ST_CHECK: begin
          if (last_ch) begin
            state_q <= ST_FIN;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_desc_loader.sv
module frame_desc_loader
  import fdl_pkg::*;
#(
  parameter int          NUM_CH  = 7,
  parameter logic [31:0] W0_BASE = 32'h1000_0000,
  parameter logic [31:0] W0_SIZE = 32'h0100_0000,
  parameter logic [31:0] W1_BASE = 32'h4000_0000,
  parameter logic [31:0] W1_SIZE = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic [NUM_CH-1:0] branch_evt,
  output logic [NUM_CH-1:0] bus_err
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][31:0] br_q, ptr_q, src_q, id_q, cmd_q;
  logic [31:0]     cand_addr, chk_src;
  logic [CH_W-1:0] cur_ch;
  logic            br_clr, src_clr, desc_ok, src_ok;
  logic [3:0]      ld_we;

  fdl_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start_i   (frame_start),
    .ch_en_i         (ch_enable),
    .br_i            (br_q),
    .ptr_i           (ptr_q),
    .src_i           (src_q),
    .desc_ok_i       (desc_ok),
    .src_ok_i        (src_ok),
    .cand_addr_o     (cand_addr),
    .chk_src_o       (chk_src),
    .cur_ch_o        (cur_ch),
    .br_clr_o        (br_clr),
    .src_clr_o       (src_clr),
    .ld_we_o         (ld_we),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_addr_o  (mem_req_addr),
    .mem_rsp_valid_i (mem_rsp_valid),
    .busy_o          (busy),
    .done_o          (done),
    .bus_err_o       (bus_err),
    .branch_evt_o    (branch_evt)
  );

  fdl_win_check #(.SPAN(16), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
                  .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)) u_desc_win (
    .addr_i (cand_addr),
    .ok_o   (desc_ok)
  );

  fdl_win_check #(.SPAN(1), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
                  .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)) u_src_win (
    .addr_i (chk_src),
    .ok_o   (src_ok)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_br, sel_ptr, is_cur;
    assign sel_br  = (reg_addr == 12'(BR_OFF + 12'(4 * c)));
    assign sel_ptr = (reg_addr == 12'(CH_OFF + 12'(CH_STRIDE * c)));
    assign is_cur  = (cur_ch == CH_W'(c));

    fdl_chan_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_br_we   (reg_wr && sel_br),
      .sw_ptr_we  (reg_wr && sel_ptr),
      .sw_wdata   (reg_wdata),
      .hw_br_clr  (br_clr && is_cur),
      .hw_src_clr (src_clr),
      .hw_we      (is_cur ? ld_we : 4'h0),
      .hw_data    (mem_rsp_data),
      .br_o       (br_q[c]),
      .ptr_o      (ptr_q[c]),
      .src_o      (src_q[c]),
      .id_o       (id_q[c]),
      .cmd_o      (cmd_q[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == 12'(BR_OFF + 12'(4 * c)))              reg_rdata = br_q[c];
      if (reg_addr == 12'(CH_OFF + 12'(CH_STRIDE * c)))      reg_rdata = ptr_q[c];
      if (reg_addr == 12'(CH_OFF + 12'(CH_STRIDE * c + 4)))  reg_rdata = src_q[c];
      if (reg_addr == 12'(CH_OFF + 12'(CH_STRIDE * c + 8)))  reg_rdata = id_q[c];
      if (reg_addr == 12'(CH_OFF + 12'(CH_STRIDE * c + 12))) reg_rdata = cmd_q[c];
    end
  end
endmodule

// File: rtl/fdl_checker.sv
module fdl_checker #(
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              busy,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [31:0]       mem_req_addr,
  input logic [NUM_CH-1:0] bus_err,
  input logic [NUM_CH-1:0] branch_evt
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && (bus_err == '0) && (branch_evt == '0));

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_start));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  p_err_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_err));

  p_evt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(branch_evt));
endmodule

bind frame_desc_loader fdl_checker #(.NUM_CH(NUM_CH)) u_fdl_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .bus_err       (bus_err),
  .branch_evt    (branch_evt)
);

// File: tb/frame_desc_loader_tb_top.sv
module frame_desc_loader_tb_top;
  localparam int NCH = 7;
  localparam logic [32:0] W0B = 33'h0_1000_0000, W0S = 33'h0_0100_0000;
  localparam logic [32:0] W1B = 33'h0_4000_0000, W1S = 33'h0_0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [NCH-1:0] ch_enable = '0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic busy, done;
  logic [NCH-1:0] branch_evt, bus_err;

  always #5 clk = ~clk;

  frame_desc_loader #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_enable(ch_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .branch_evt(branch_evt), .bus_err(bus_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory contents derived from the address
  function automatic logic [31:0] mdata(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:4], 4'h0};
    case (a[3:2])
      2'd0: mdata = b + 32'h40;
      2'd1: mdata = b[8] ? 32'h0 : (b[9] ? 32'h2000_0000 : 32'h1000_0000 + {12'h0, b[19:0]});
      2'd2: mdata = ~b;
      default: mdata = b ^ 32'h0060_0004;
    endcase
  endfunction

  function automatic bit in_win(input logic [31:0] a, input int span);
    logic [32:0] x;
    x = {1'b0, a};
    in_win = (x >= W0B && x + 33'(span) <= W0B + W0S) || (x >= W1B && x + 33'(span) <= W1B + W1S);
  endfunction

  // memory model and event accumulators
  logic acc_clr = 1'b0;
  int cyc = 0;
  bit pend = 0;
  int dly = 0;
  logic [31:0] pdata;
  logic [NCH-1:0] acc_err, acc_evt;
  int done_cnt, log_n;
  logic [31:0] log_a [0:63];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 0;
      mem_req_ready <= 1'b0;
    end else begin
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= pdata;
          pend <= 0;
        end else dly <= dly - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1;
        pdata <= mdata(mem_req_addr);
        dly <= int'(mem_req_addr[2]);
        if (log_n < 64) log_a[log_n] <= mem_req_addr;
        log_n <= log_n + 1;
      end
    end
    if (acc_clr) begin
      acc_err <= '0; acc_evt <= '0; done_cnt <= 0; log_n <= 0;
    end else begin
      acc_err <= acc_err | bus_err;
      acc_evt <= acc_evt | branch_evt;
      done_cnt <= done_cnt + int'(done);
    end
  end

  // reference model state
  logic [31:0] m_br [NCH], m_ptr [NCH], m_src [NCH], m_id [NCH], m_cmd [NCH];
  logic [NCH-1:0] exp_err, exp_evt;
  logic [31:0] exp_log [0:63];
  int exp_n;

  task automatic model_frame(input logic [NCH-1:0] en);
    logic [31:0] a;
    exp_err = '0; exp_evt = '0; exp_n = 0;
    for (int c = 0; c < NCH; c++) m_src[c] = '0;
    for (int c = 0; c < NCH; c++) begin
      if (en[c]) begin
        if (m_br[c][0]) begin
          a = {m_br[c][31:4], 4'h0};
          if (m_br[c][1]) exp_evt[c] = 1'b1;
          m_br[c][0] = 1'b0;
        end else a = m_ptr[c];
        if (!in_win(a, 16)) exp_err[c] = 1'b1;
        else begin
          for (int k = 0; k < 4; k++) begin
            exp_log[exp_n] = a + 32'(4 * k);
            exp_n++;
          end
          m_ptr[c] = mdata(a);
          m_src[c] = mdata(a + 4);
          m_id[c]  = mdata(a + 8);
          m_cmd[c] = mdata(a + 12);
          if (m_src[c] == 0 || !in_win(m_src[c], 1)) exp_err[c] = 1'b1;
        end
      end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(12'(12'h100 + 4 * c), d);      chk(d == m_br[c],  {tag, " R2/R6 branch"}, d, m_br[c]);
      rd(12'(12'h200 + 16 * c), d);     chk(d == m_ptr[c], {tag, " R7/R9 next ptr"}, d, m_ptr[c]);
      rd(12'(12'h200 + 16 * c + 4), d); chk(d == m_src[c], {tag, " R4/R9 source"}, d, m_src[c]);
      rd(12'(12'h200 + 16 * c + 8), d); chk(d == m_id[c],  {tag, " R5/R9 id"}, d, m_id[c]);
      rd(12'(12'h200 + 16 * c + 12), d);chk(d == m_cmd[c], {tag, " R5/R9 command"}, d, m_cmd[c]);
    end
  endtask

  task automatic run_frame(input logic [NCH-1:0] en, input bit mid_start,
                           input bit collide, input logic [31:0] cw, input string tag);
    int w;
    model_frame(en);
    if (collide) m_br[0] = cw & 32'hFFFF_FFF3;
    @(negedge clk);
    acc_clr = 1'b1; ch_enable = en;
    @(negedge clk);
    acc_clr = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (collide) begin
      reg_wr = 1'b1; reg_addr = 12'h100; reg_wdata = cw;   // lands in the branch-consume cycle (R13)
      @(negedge clk);
      reg_wr = 1'b0;
    end
    if (mid_start) begin
      repeat (4) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R4 done count"}, 32'(done_cnt), 32'd1);
    chk(busy == 1'b0, {tag, " R4 idle after done"}, 32'(busy), 32'd0);
    chk(acc_err == exp_err, {tag, " R8/R11 bus_err"}, 32'(acc_err), 32'(exp_err));
    chk(acc_evt == exp_evt, {tag, " R6 branch_evt"}, 32'(acc_evt), 32'(exp_evt));
    chk(log_n == exp_n, {tag, " R5/R10 request count"}, 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_a[i] == exp_log[i], {tag, " R9/R12 address order"}, log_a[i], exp_log[i]);
    check_regs(tag);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      m_br[c] = '0; m_ptr[c] = '0; m_src[c] = '0; m_id[c] = '0; m_cmd[c] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req_valid && bus_err == 0 && branch_evt == 0,
        "R1 outputs idle", {busy, done, mem_req_valid, 29'(bus_err)}, 32'h0);
    check_regs("R1 reset");

    // R2 branch mask, R3 pointer mask, read-only and unmapped
    wr(12'h10C, 32'hFFFF_FFFF); m_br[3] = 32'hFFFF_FFF3;
    rd(12'h10C, d); chk(d == 32'hFFFF_FFF3, "R2 branch write mask", d, 32'hFFFF_FFF3);
    wr(12'h200, 32'h1000_000F); m_ptr[0] = 32'h1000_0000;
    rd(12'h200, d); chk(d == 32'h1000_0000, "R3 pointer low bits", d, 32'h1000_0000);
    wr(12'h204, 32'hDEAD_BEEF);
    rd(12'h204, d); chk(d == 32'h0, "R3 source read-only", d, 32'h0);
    wr(12'h20C, 32'h1234_5678);
    rd(12'h20C, d); chk(d == 32'h0, "R3 command read-only", d, 32'h0);
    rd(12'h0FC, d); chk(d == 32'h0, "R3 unmapped read", d, 32'h0);

    wr(12'h210, 32'h1000_0100); m_ptr[1] = 32'h1000_0100;   // zero source
    wr(12'h220, 32'h4000_FFF0); m_ptr[2] = 32'h4000_FFF0;   // last legal slot of window 1
    wr(12'h240, 32'h1000_0200); m_ptr[4] = 32'h1000_0200;   // source out of window
    wr(12'h250, 32'h1000_0400); m_ptr[5] = 32'h1000_0400;
    wr(12'h114, 32'h1000_0803); m_br[5]  = 32'h1000_0803;   // branch with event
    wr(12'h260, 32'h1000_0500); m_ptr[6] = 32'h1000_0500;
    wr(12'h118, 32'h4000_1001); m_br[6]  = 32'h4000_1001;   // branch without event

    run_frame(7'h7F, 0, 0, 0, "all channels");
    run_frame(7'h55, 0, 0, 0, "even channels");
    run_frame(7'h2A, 1, 0, 0, "odd channels, restart while busy");
    run_frame(7'h00, 0, 0, 0, "no channels");

    wr(12'h100, 32'h1000_0C03); m_br[0] = 32'h1000_0C03;
    run_frame(7'h01, 0, 1, 32'h1000_0E01, "R13 collision");
    run_frame(7'h03, 0, 0, 0, "after collision");
    for (int m = 1; m < 128; m += 9)
      run_frame(7'(m), 0, 0, 0, "mask sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule